// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept or discarded by looking at its destination address. The receive path hands it the six destination address bytes in the order they arrived on the wire, with a start strobe on the first byte. It may also give a frame length indication. The block answers with a one-cycle decision pulse that carries an accept flag.

Software programs the filter through a 32-bit word register interface. There are two exact-match station addresses, each with its own enable. A broadcast enable accepts the all-ones address. A 64-entry group table is indexed by a 6-bit hash of the address, and a control bit lets non-multicast addresses use that table as well. Frames known to be shorter than twelve bytes are always discarded. The configuration is captured when a frame starts, so software writes made during a frame only apply to the frames that follow.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every register reads 0 and every frame is dropped.
- R2: Register words sit at byte offsets 0x00 (address A low), 0x04 (address A high), 0x08 (address B low), 0x0C (address B high), 0x10 (table bits 31:0), 0x14 (table bits 63:32) and 0x1C (control). A read returns the full 32-bit value last written. Any other offset, or one with bits 1:0 nonzero, reads 0 and ignores writes.
- R3: Wire byte k (k=0..3) of the station address is bits 8k+7:8k of its low word, and bytes 4 and 5 are bits 7:0 and 15:8 of its high word. With control bit 0 set, a frame whose destination equals address A is accepted.
- R4: With control bit 1 set, a frame whose destination equals address B is accepted. With the enable bit clear, a matching address alone does not accept.
- R5: With control bit 3 set, a destination of all ones is accepted.
- R6: The group table is consulted only when bit 0 of wire byte 0 is 1 (multicast) or control bit 2 is set. Otherwise the table lookup counts as a miss.
- R7: The hash index is formed from the 48 address bits taken as a stream, wire byte 0 first and LSB first within each byte. The stream is split into eight 6-bit chunks, which are XORed together; stream bit k lands on index bit k mod 6.
- R8: An index below 32 selects that bit of the table low word, and an index of 32 or more selects bit (index-32) of the high word. A set bit accepts the frame.
- R9: A length indication below 12 forces a drop, whatever the address. It is honoured from the start byte up to and including the cycle in which the decision register is loaded. A length of 12 or more does not block acceptance.
- R10: The decision pulse is high for exactly one cycle. It is loaded by the second rising edge after the edge that samples wire byte 5.
- R11: Register writes made after a frame's start byte do not change that frame's decision; they apply from the next start byte on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| da_valid | input | 1 | Destination address byte valid |
| da_sof | input | 1 | Marks wire byte 0 of a new frame |
| da_byte | input | 8 | Destination address byte |
| len_valid | input | 1 | Frame length indication valid |
| len_bytes | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted (meaningful while dec_valid) |

## Verification
Register reads are combinational, so read data is sampled in the same cycle the offset is driven. Writes are visible one edge after the strobe. For a frame, the bench drives byte 5 and then counts edges. It samples dec_valid low just before the second edge, high with the accept flag just after it, and low again one cycle later. Short lengths are presented either one edge after byte 5 or on the deciding edge itself, so both ends of the R9 window are exercised.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_BITS  = 8 * ADDR_BYTES;
    localparam int HASH_W     = 6;
    localparam int TBL_BITS   = 1 << HASH_W;
    localparam int N_CHUNKS   = ADDR_BITS / HASH_W;
    localparam int CTRL_W     = 4;

    localparam int CB_EN_A   = 0;
    localparam int CB_EN_B   = 1;
    localparam int CB_GRP_UC = 2;
    localparam int CB_EN_BC  = 3;

    typedef struct packed {
        logic [ADDR_BITS-1:0] sta_a;
        logic [ADDR_BITS-1:0] sta_b;
        logic [TBL_BITS-1:0]  tbl;
        logic [CTRL_W-1:0]    ctrl;
    } cfg_t;

    function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_BITS-1:0] a);
        logic [HASH_W-1:0] h;
        h = '0;
        for (int c = 0; c < N_CHUNKS; c++) begin
            h = h ^ a[c*HASH_W +: HASH_W];
        end
        return h;
    endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_start,
    output cfg_t              cfg
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int HI_W  = ADDR_BITS - DATA_W;

    localparam logic [IDX_W-1:0] W_A_LO = IDX_W'(0);
    localparam logic [IDX_W-1:0] W_A_HI = IDX_W'(1);
    localparam logic [IDX_W-1:0] W_B_LO = IDX_W'(2);
    localparam logic [IDX_W-1:0] W_B_HI = IDX_W'(3);
    localparam logic [IDX_W-1:0] W_T_LO = IDX_W'(4);
    localparam logic [IDX_W-1:0] W_T_HI = IDX_W'(5);
    localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(7);

    typedef struct packed {
        logic [DATA_W-1:0] a_lo;
        logic [DATA_W-1:0] a_hi;
        logic [DATA_W-1:0] b_lo;
        logic [DATA_W-1:0] b_hi;
        logic [DATA_W-1:0] t_lo;
        logic [DATA_W-1:0] t_hi;
        logic [DATA_W-1:0] ctl;
        cfg_t              snap;
    } regs_t;

    regs_t d, q;
    logic              aligned;
    logic [IDX_W-1:0]  widx;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign widx    = reg_addr[ADDR_W-1:2];

    always_comb begin
        d = q;
        if (reg_we && aligned) begin
            case (widx)
                W_A_LO:  d.a_lo = reg_wdata;
                W_A_HI:  d.a_hi = reg_wdata;
                W_B_LO:  d.b_lo = reg_wdata;
                W_B_HI:  d.b_hi = reg_wdata;
                W_T_LO:  d.t_lo = reg_wdata;
                W_T_HI:  d.t_hi = reg_wdata;
                W_CTRL:  d.ctl  = reg_wdata;
                default: ;
            endcase
        end
        if (frame_start) begin
            d.snap.sta_a = {q.a_hi[HI_W-1:0], q.a_lo};
            d.snap.sta_b = {q.b_hi[HI_W-1:0], q.b_lo};
            d.snap.tbl   = {q.t_hi, q.t_lo};
            d.snap.ctrl  = q.ctl[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (widx)
                W_A_LO:  reg_rdata = q.a_lo;
                W_A_HI:  reg_rdata = q.a_hi;
                W_B_LO:  reg_rdata = q.b_lo;
                W_B_HI:  reg_rdata = q.b_hi;
                W_T_LO:  reg_rdata = q.t_lo;
                W_T_HI:  reg_rdata = q.t_hi;
                W_CTRL:  reg_rdata = q.ctl;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign cfg = q.snap;

    // Configuration used by a frame only moves on a start byte
    p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg));
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       da_valid,
    input  logic       da_sof,
    input  logic [7:0] da_byte,
    input  cfg_t       cfg,
    output logic       addr_done,
    output logic       hit_valid,
    output logic       hit
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic [CNT_W-1:0]     cnt;
        logic                 done;
        logic                 hv;
        logic                 hit;
    } mstate_t;

    mstate_t d, q;

    logic [1:0]        sta_en;
    logic [1:0]        sta_eq;
    logic              bc_hit;
    logic              grp_ok;
    logic              grp_hit;
    logic [HASH_W-1:0] hidx;

    // Exact-match comparators, one per station address
    for (genvar s = 0; s < 2; s++) begin : g_sta
        if (s == 0) begin : g_a
            assign sta_en[s] = cfg.ctrl[CB_EN_A];
            assign sta_eq[s] = (q.addr == cfg.sta_a);
        end else begin : g_b
            assign sta_en[s] = cfg.ctrl[CB_EN_B];
            assign sta_eq[s] = (q.addr == cfg.sta_b);
        end
    end

    assign bc_hit  = cfg.ctrl[CB_EN_BC] && (&q.addr);
    assign grp_ok  = q.addr[0] || cfg.ctrl[CB_GRP_UC];
    assign hidx    = fold_hash(q.addr);
    assign grp_hit = grp_ok && cfg.tbl[hidx];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (da_valid && da_sof) begin
            d.addr[7:0] = da_byte;
            d.cnt       = CNT_W'(1);
        end else if (da_valid && q.cnt != '0 && q.cnt < CNT_FULL) begin
            for (int i = 1; i < ADDR_BYTES; i++) begin
                if (q.cnt == CNT_W'(i)) d.addr[8*i +: 8] = da_byte;
            end
            d.cnt  = q.cnt + CNT_W'(1);
            d.done = (q.cnt == CNT_LAST);
        end
        d.hv  = q.done;
        d.hit = q.done && ((|(sta_en & sta_eq)) || bc_hit || grp_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_done = q.done;
    assign hit_valid = q.hv;
    assign hit       = q.hit;

    p_exact_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && cfg.ctrl[CB_EN_A] && q.addr == cfg.sta_a) |=> q.hit);

    p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && cfg.ctrl[CB_EN_BC] && (&q.addr)) |=> q.hit);

    p_uc_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.addr[0] && !cfg.ctrl[CB_GRP_UC]
         && !(cfg.ctrl[CB_EN_A] && q.addr == cfg.sta_a)
         && !(cfg.ctrl[CB_EN_B] && q.addr == cfg.sta_b)) |=> !q.hit);

    p_stage_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.done, q.hv}));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              da_valid,
    input  logic              da_sof,
    input  logic [7:0]        da_byte,
    input  logic              len_valid,
    input  logic [LEN_W-1:0]  len_bytes,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

    typedef struct packed {
        logic short_seen;
        logic dv;
        logic acc;
    } dec_t;

    dec_t d, q;
    cfg_t cfg;
    logic frame_start;
    logic addr_done;
    logic hit_valid;
    logic hit;
    logic len_short;
    logic short_now;

    assign frame_start = da_valid && da_sof;

    rxf_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .frame_start (frame_start),
        .cfg         (cfg)
    );

    rxf_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .da_valid  (da_valid),
        .da_sof    (da_sof),
        .da_byte   (da_byte),
        .cfg       (cfg),
        .addr_done (addr_done),
        .hit_valid (hit_valid),
        .hit       (hit)
    );

    assign len_short = len_valid && (len_bytes < LEN_MIN);
    assign short_now = q.short_seen || len_short;

    always_comb begin
        d            = q;
        d.short_seen = frame_start ? 1'b0 : short_now;
        d.dv         = hit_valid;
        d.acc        = hit_valid && hit && !short_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dec_valid  = q.dv;
    assign dec_accept = q.acc;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(addr_done, 2));

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_late_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && len_short) |=> !dec_accept);

    p_acc_in_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        da_valid = 1'b0;
    logic        da_sof = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        len_valid = 1'b0;
    logic [15:0] len_bytes = '0;
    logic        dec_valid;
    logic        dec_accept;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_reg [8];

    always #2.5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid),
        .da_sof(da_sof), .da_byte(da_byte), .len_valid(len_valid),
        .len_bytes(len_bytes), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] m_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 48; k++) h[k % 6] ^= a[k];
        return h;
    endfunction

    function automatic logic m_accept(input logic [47:0] a, input int len);
        logic [47:0] sa = {m_reg[1][15:0], m_reg[0]};
        logic [47:0] sb = {m_reg[3][15:0], m_reg[2]};
        logic [3:0]  c  = m_reg[7][3:0];
        logic [5:0]  h  = m_hash(a);
        logic tb;
        logic ok;
        tb = (h < 32) ? m_reg[4][h[4:0]] : m_reg[5][h[4:0]];
        ok = (c[0] && a == sa) || (c[1] && a == sb) || (c[3] && a == '1)
             || ((a[0] || c[2]) && tb);
        if (len >= 0 && len < 12) ok = 1'b0;
        return ok;
    endfunction

    task automatic wr(input int idx, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(idx * 4); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        m_reg[idx] = v;
    endtask

    task automatic rd(input logic [4:0] off, output logic [31:0] v);
        @(negedge clk);
        reg_addr = off;
        #1 v = reg_rdata;
    endtask

    // slot 0: no length, 1: one edge after byte 5, 2: on the deciding edge
    task automatic frame(input logic [47:0] a, input int len, input int slot,
                         input logic exp, input string req,
                         input bit mid_wr = 0, input int mid_idx = 0,
                         input logic [31:0] mid_val = '0);
        @(negedge clk);
        da_valid = 1'b1; da_sof = 1'b1; da_byte = a[7:0];
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            da_sof = 1'b0; da_byte = a[8*i +: 8];
            reg_we = (mid_wr && i == 3);
            reg_addr = 5'(mid_idx * 4); reg_wdata = mid_val;
        end
        @(negedge clk);
        reg_we = 1'b0; da_valid = 1'b0;
        if (mid_wr) m_reg[mid_idx] = mid_val;
        len_valid = (slot == 1); len_bytes = 16'(len);
        @(negedge clk);
        len_valid = (slot == 2);
        check({"R10 early ", req}, {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        len_valid = 1'b0;
        check({"R10 valid ", req}, {31'd0, dec_valid}, 32'd1);
        check(req, {31'd0, dec_accept}, {31'd0, exp});
        @(negedge clk);
        check({"R10 pulse ", req}, {31'd0, dec_valid}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [47:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            check("R1 reset read", v, 32'd0);
        end
        frame(48'hffffffffffff, -1, 0, 1'b0, "R1 drop after reset");
        frame(48'h000000000001, -1, 0, 1'b0, "R1 drop mcast after reset");

        // R2: readback and unmapped offsets
        wr(0, 32'h44332211); wr(1, 32'hdead6655);
        wr(2, 32'hccbbaa10); wr(3, 32'hbeefeedd);
        wr(4, 32'h0); wr(5, 32'h0); wr(7, 32'h0);
        rd(5'h00, v); check("R2 read A lo", v, 32'h44332211);
        rd(5'h04, v); check("R2 read A hi", v, 32'hdead6655);
        rd(5'h08, v); check("R2 read B lo", v, 32'hccbbaa10);
        rd(5'h0c, v); check("R2 read B hi", v, 32'hbeefeedd);
        @(negedge clk); reg_we = 1'b1; reg_addr = 5'h18; reg_wdata = 32'hffffffff;
        @(negedge clk); reg_we = 1'b1; reg_addr = 5'h01; reg_wdata = 32'h12345678;
        @(negedge clk); reg_we = 1'b0;
        rd(5'h18, v); check("R2 unmapped reads zero", v, 32'd0);
        rd(5'h00, v); check("R2 misaligned write ignored", v, 32'h44332211);
        rd(5'h01, v); check("R2 misaligned read zero", v, 32'd0);

        // R3 / R4: exact match and enables
        frame(48'h665544332211, -1, 0, 1'b0, "R3 A disabled");
        wr(7, 32'h1);
        frame(48'h665544332211, -1, 0, 1'b1, "R3 A match byte order");
        frame(48'h112233445566, -1, 0, 1'b0, "R3 A reversed bytes");
        frame(48'heeddccbbaa10, -1, 0, 1'b0, "R4 B disabled");
        wr(7, 32'h2);
        frame(48'heeddccbbaa10, -1, 0, 1'b1, "R4 B match");
        frame(48'h665544332211, -1, 0, 1'b0, "R4 A off when only B on");

        // R5: broadcast
        frame(48'hffffffffffff, -1, 0, 1'b0, "R5 bcast disabled");
        wr(7, 32'h8);
        frame(48'hffffffffffff, -1, 0, 1'b1, "R5 bcast accepted");
        frame(48'hfffffffffffe, -1, 0, 1'b0, "R5 near-bcast unicast");

        // R6: unicast table use gated by control bit 2
        wr(7, 32'h0); wr(4, 32'hffffffff); wr(5, 32'hffffffff);
        frame(48'h0000000000fe, -1, 0, 1'b0, "R6 unicast skips table");
        frame(48'h000000000003, -1, 0, 1'b1, "R6 multicast uses table");
        wr(7, 32'h4);
        frame(48'h0000000000fe, -1, 0, 1'b1, "R6 unicast with bit2");

        // R7 / R8: hash index and table halves
        wr(7, 32'h0); wr(4, 32'h2); wr(5, 32'h0);
        frame(48'h000000000001, -1, 0, 1'b1, "R8 index 1 low word");
        wr(4, 32'hfffffffd);
        frame(48'h000000000001, -1, 0, 1'b0, "R8 index 1 bit clear");
        wr(4, 32'h0); wr(5, 32'h2);
        frame(48'h000000000021, -1, 0, 1'b1, "R8 index 33 high word");
        a = 48'h5e0001c7a301;
        wr(5, 32'h0); wr(4, 32'h0);
        if (m_hash(a) < 32) wr(4, 32'h1 << m_hash(a)[4:0]);
        else                wr(5, 32'h1 << m_hash(a)[4:0]);
        frame(a, -1, 0, 1'b1, "R7 folded hash hit");
        frame(a ^ 48'h000000000040, -1, 0, 1'b0, "R7 one-bit change misses");

        // R9: short frames
        wr(7, 32'h8);
        frame(48'hffffffffffff, 11, 1, 1'b0, "R9 short early");
        frame(48'hffffffffffff, 5, 2, 1'b0, "R9 short on decision edge");
        frame(48'hffffffffffff, 12, 1, 1'b1, "R9 length 12 accepted");
        frame(48'hffffffffffff, 64, 2, 1'b1, "R9 long late accepted");

        // R11: write mid-frame applies next frame
        wr(7, 32'h1);
        frame(48'h665544332211, -1, 0, 1'b1, "R11 old config kept", 1'b1, 0, 32'h0);
        frame(48'h665544332211, -1, 0, 1'b0, "R11 new config next frame");

        // Random frames against the bench model
        for (int n = 0; n < 300; n++) begin
            int kind, len, slot;
            logic e;
            if (n % 25 == 0) begin
                wr(0, $urandom); wr(1, $urandom); wr(2, $urandom); wr(3, $urandom);
                wr(4, $urandom & $urandom); wr(5, $urandom & $urandom);
                wr(7, $urandom % 16);
            end
            kind = $urandom % 5;
            case (kind)
                0: a = {m_reg[1][15:0], m_reg[0]};
                1: a = {m_reg[3][15:0], m_reg[2]};
                2: a = '1;
                3: a = {$urandom, $urandom} | 48'h1;
                default: a = {$urandom, $urandom};
            endcase
            slot = $urandom % 3;
            len  = ($urandom % 4 == 0) ? int'($urandom % 12) : 12 + int'($urandom % 1500);
            e = m_accept(a, (slot == 0) ? -1 : len);
            frame(a, len, slot, e, "R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule